// File: doc/BRIEF.md
# Guarded Configuration Register Writer

This block sits behind a byte-oriented host command interface and carries out the "write configuration" command. Each incoming byte comes with a flag that says whether it is a command code or a parameter. When the configuration-write code arrives and the line engine is idle, the block acknowledges the code. It then takes the next parameter byte as the new configuration value. The value is committed only if its upper nibble is the bitwise inverse of its lower nibble. If the line engine reports busy when the code arrives, the whole command is refused.

The stored configuration drives three enables towards the line engine: active pullup, strong pullup and speed select. After a command completes, the block points the host read selector at the configuration register, so the host can read the value back and confirm it. A successful commit also clears the device-reset status flag.

Top module: `cfg_guard_top`

## Requirements
- R1: A byte with `byteIsCmd`=1 and value 0xD2, received while `lineBusy`=0, gives `ackValid`=1 with `ackOk`=1 in the cycle after it is accepted. The next parameter byte (`byteIsCmd`=0) is also acknowledged with `ackOk`=1 one cycle after it is accepted.
- R2: A parameter whose bits 7..4 equal the inverse of bits 3..0 is stored in the same clock edge that registers its acknowledge. `cfgRead` then shows 0 in bits 7..4 and the stored nibble in bits 3..0.
- R3: A parameter that fails the inverse check is still acknowledged with `ackOk`=1, but the stored configuration keeps its old value.
- R4: If `lineBusy`=1 when the 0xD2 code is accepted, the code is acknowledged with `ackOk`=0. The following parameter is also acknowledged with `ackOk`=0, and nothing is stored.
- R5: A committed write drives `rstStatus` to 0 in the same cycle that the configuration changes. A rejected or refused write leaves `rstStatus` unchanged. `rstStatus` returns to 1 only through reset.
- R6: `readPtrCfg` goes to 1 when a parameter is acknowledged with `ackOk`=1, whether the inverse check passes or fails. A refused command does not change it.
- R7: The stored bits map as follows: bit 0 drives `apuEn`, bit 2 drives `spuEn` and bit 3 drives `speedSel`. Bit 1 is stored and read back but drives no output.
- R8: After reset, the stored configuration is 0x0, `rstStatus`=1, `readPtrCfg`=0 and `ackValid`=0.
- R9: A command code other than 0xD2 produces no acknowledge and cancels a pending parameter wait. A parameter byte that arrives with no pending command produces no acknowledge and changes nothing.
- R10: `lineBusy` is sampled only when the code arrives. If busy rises while the parameter arrives, the parameter is not blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A byte is presented this cycle |
| byteIsCmd | input | 1 | 1: the byte is a command code, 0: the byte is a parameter |
| byteData | input | 8 | Byte value |
| lineBusy | input | 1 | Line engine busy flag |
| ackValid | output | 1 | Acknowledge decision valid (one-cycle pulse) |
| ackOk | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| cfgRead | output | 8 | Read-back value of the configuration register, upper nibble zero |
| apuEn | output | 1 | Active pullup enable |
| spuEn | output | 1 | Strong pullup enable |
| speedSel | output | 1 | Speed select |
| readPtrCfg | output | 1 | 1 = host read pointer selects the configuration register |
| rstStatus | output | 1 | Device-reset status flag |

## Verification
The assertions check these properties on every cycle:
- A rejected parameter never alters the register.
- A good commit drops `rstStatus`.
- A code that arrives while the engine is busy is refused.
- Foreign codes stay silent.
- `rstStatus` and `readPtrCfg` only ever move in one direction.

Only the bench's scenarios can show the following, because they are checked against a behavioural model over whole command sequences:
- The exact read-back values.
- The field mapping, including the inert reserved bit.
- That busy is sampled only at the code.
- That a parameter wait is cancelled by another code.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  parameter int BYTE_W = 8;
  parameter int NIB_W = BYTE_W / 2;
  parameter logic [BYTE_W-1:0] CFG_WRITE_CODE = 8'hD2;
  parameter int BIT_APU = 0;
  parameter int BIT_SPU = 2;
  parameter int BIT_SPD = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PARAM = 2'd1,
    ST_SKIP  = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic commit;
    logic clearRst;
    logic selCfg;
  } cfgStrobes_t;
endpackage

// File: rtl/cfg_guard_ctrl.sv
module cfg_guard_ctrl
  import cfg_guard_pkg::*;
#(
  parameter int W = BYTE_W,
  parameter logic [W-1:0] CODE = CFG_WRITE_CODE
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         byteValid,
  input  logic         byteIsCmd,
  input  logic [W-1:0] byteData,
  input  logic         lineBusy,
  output logic         ackValid,
  output logic         ackOk,
  output cfgStrobes_t  stb
);
  ctrlState_t state, nextState;
  logic ackNext, okNext;

  always_comb begin
    nextState = state;
    stb = '0;
    ackNext = 1'b0;
    okNext = 1'b0;
    if (byteValid) begin
      if (byteIsCmd) begin
        if (byteData == CODE) begin
          ackNext = 1'b1;
          okNext = !lineBusy;
          nextState = lineBusy ? ST_SKIP : ST_PARAM;
        end else begin
          nextState = ST_IDLE;
        end
      end else begin
        unique case (state)
          ST_PARAM: begin
            ackNext = 1'b1;
            okNext = 1'b1;
            stb.commit = 1'b1;
            stb.clearRst = 1'b1;
            stb.selCfg = 1'b1;
            nextState = ST_IDLE;
          end
          ST_SKIP: begin
            ackNext = 1'b1;
            nextState = ST_IDLE;
          end
          default: nextState = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ackValid <= 1'b0;
      ackOk <= 1'b0;
    end else begin
      state <= nextState;
      ackValid <= ackNext;
      ackOk <= okNext;
    end
  end

  // R4: a code that arrives while the engine is busy is answered with a not-acknowledge
  a_r4_busy_nack: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteIsCmd && byteData == CODE && lineBusy) |=> (ackValid && !ackOk));
  // R9: foreign command codes stay silent
  a_r9_foreign_silent: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteIsCmd && byteData != CODE) |=> !ackValid);
  // R1: every acknowledge answers a byte from the previous cycle
  a_r1_ack_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(byteValid));
endmodule

// File: rtl/cfg_guard_dp.sv
module cfg_guard_dp
  import cfg_guard_pkg::*;
#(
  parameter int W = BYTE_W,
  localparam int NW = W / 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] byteData,
  input  cfgStrobes_t  stb,
  output logic [W-1:0] cfgRead,
  output logic         apuEn,
  output logic         spuEn,
  output logic         speedSel,
  output logic         readPtrCfg,
  output logic         rstStatus
);
  logic [NW-1:0] cfgReg;
  logic paramGood;

  assign paramGood = (byteData[W-1:NW] == ~byteData[NW-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
      rstStatus <= 1'b1;
      readPtrCfg <= 1'b0;
    end else begin
      if (stb.commit && paramGood) cfgReg <= byteData[NW-1:0];
      if (stb.clearRst && paramGood) rstStatus <= 1'b0;
      if (stb.selCfg) readPtrCfg <= 1'b1;
    end
  end

  assign cfgRead = {{(W-NW){1'b0}}, cfgReg};
  assign apuEn = cfgReg[BIT_APU];
  assign spuEn = cfgReg[BIT_SPU];
  assign speedSel = cfgReg[BIT_SPD];

  // R3: a parameter that fails the inverse check leaves the register alone
  a_r3_bad_param_holds: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && !paramGood) |=> $stable(cfgRead));
  // R5: a good commit drops the reset flag
  a_r5_rst_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && paramGood) |=> !rstStatus);
  // R5: the reset flag never comes back without reset
  a_r5_rst_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !rstStatus |=> !rstStatus);
  // R6: the pointer stays on the configuration register once moved
  a_r6_ptr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    readPtrCfg |=> readPtrCfg);
endmodule

// File: rtl/cfg_guard_top.sv
module cfg_guard_top
  import cfg_guard_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         byteValid,
  input  logic         byteIsCmd,
  input  logic [W-1:0] byteData,
  input  logic         lineBusy,
  output logic         ackValid,
  output logic         ackOk,
  output logic [W-1:0] cfgRead,
  output logic         apuEn,
  output logic         spuEn,
  output logic         speedSel,
  output logic         readPtrCfg,
  output logic         rstStatus
);
  cfgStrobes_t stb;

  cfg_guard_ctrl #(.W(W)) i_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIsCmd(byteIsCmd),
    .byteData(byteData), .lineBusy(lineBusy), .ackValid(ackValid),
    .ackOk(ackOk), .stb(stb)
  );

  cfg_guard_dp #(.W(W)) i_dp (
    .clk(clk), .rstN(rstN), .byteData(byteData), .stb(stb),
    .cfgRead(cfgRead), .apuEn(apuEn), .spuEn(spuEn), .speedSel(speedSel),
    .readPtrCfg(readPtrCfg), .rstStatus(rstStatus)
  );
endmodule

// File: tb/test_cfg_guard_top.sv
module test_cfg_guard_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0, byteIsCmd = 1'b0, lineBusy = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic ackValid, ackOk, apuEn, spuEn, speedSel, readPtrCfg, rstStatus;
  logic [7:0] cfgRead;

  int total = 0, bad = 0;
  bit finished = 0;
  string phase = "R8 reset";

  // behavioural reference state
  int mMode = 0; // 0 none pending, 1 take parameter, 2 refuse parameter
  logic [3:0] mCfg = 4'h0;
  bit mRst = 1, mPtr = 0, mAckV = 0, mAckOk = 0;

  always #2 clk = ~clk;

  cfg_guard_top i_cfg_guard_top (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIsCmd(byteIsCmd),
    .byteData(byteData), .lineBusy(lineBusy), .ackValid(ackValid), .ackOk(ackOk),
    .cfgRead(cfgRead), .apuEn(apuEn), .spuEn(spuEn), .speedSel(speedSel),
    .readPtrCfg(readPtrCfg), .rstStatus(rstStatus)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mCfg = 4'h0; mRst = 1; mPtr = 0; mAckV = 0; mAckOk = 0;
    end else begin
      mAckV = 0;
      if (byteValid) begin
        if (byteIsCmd) begin
          if (byteData == 8'hD2) begin
            mAckV = 1; mAckOk = !lineBusy; mMode = lineBusy ? 2 : 1;
          end else mMode = 0;
        end else if (mMode == 1) begin
          mAckV = 1; mAckOk = 1; mPtr = 1;
          if ((byteData >> 4) == (~byteData & 8'h0F)) begin
            mCfg = byteData[3:0]; mRst = 0;
          end
          mMode = 0;
        end else if (mMode == 2) begin
          mAckV = 1; mAckOk = 0; mMode = 0;
        end
      end
    end
    #1;
    if (!finished) begin
      check("R1 ackValid", ackValid, mAckV);
      if (mAckV) check("R4 ackOk", ackOk, mAckOk);
      check("R2 cfgRead", cfgRead, {4'h0, mCfg});
      check("R7 apuEn", apuEn, mCfg[0]);
      check("R7 spuEn", spuEn, mCfg[2]);
      check("R7 speedSel", speedSel, mCfg[3]);
      check("R5 rstStatus", rstStatus, mRst);
      check("R6 readPtrCfg", readPtrCfg, mPtr);
    end
  end

  task automatic sendByte(bit isCmd, logic [7:0] d, bit busy);
    @(negedge clk);
    byteValid = 1; byteIsCmd = isCmd; byteData = d; lineBusy = busy;
    @(negedge clk);
    byteValid = 0; lineBusy = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rstN = 1;
    idle(2);
    phase = "R1 R2 good write";     sendByte(1, 8'hD2, 0); sendByte(0, 8'hE1, 0); idle(2);
    phase = "R3 bad param";         sendByte(1, 8'hD2, 0); sendByte(0, 8'h55, 0); idle(2);
    phase = "R7 all fields";        sendByte(1, 8'hD2, 0); sendByte(0, 8'h0F, 0); idle(2);
    phase = "R7 reserved bit only"; sendByte(1, 8'hD2, 0); sendByte(0, 8'hD2, 0); idle(2);
    phase = "R4 busy refuse";       sendByte(1, 8'hD2, 1); sendByte(0, 8'h78, 0); idle(2);
    phase = "R10 busy at param";    sendByte(1, 8'hD2, 0); sendByte(0, 8'h2D, 1); idle(2);
    phase = "R9 foreign code";      sendByte(1, 8'hB4, 0); sendByte(0, 8'h87, 0); idle(2);
    phase = "R9 stray param";       sendByte(0, 8'h96, 0); idle(2);
    phase = "R9 cancel wait";       sendByte(1, 8'hD2, 0); sendByte(1, 8'hE1, 0); sendByte(0, 8'h87, 0); idle(2);
    phase = "R1 back to back";      sendByte(1, 8'hD2, 0); sendByte(0, 8'h87, 0); sendByte(1, 8'hD2, 0); sendByte(0, 8'h4B, 0);
    phase = "R8 re-reset";          @(negedge clk); rstN = 0; idle(2); rstN = 1; idle(2);
    phase = "R5 refused keeps rst"; sendByte(1, 8'hD2, 1); sendByte(0, 8'hF0, 0); idle(2);
    phase = "R2 R3 random";
    for (int i = 0; i < 400; i++) begin
      logic [3:0] lo = 4'($urandom);
      bit good = ($urandom % 2) == 1;
      if (($urandom % 4) == 0) sendByte(1, 8'($urandom), $urandom % 2);
      sendByte(1, 8'hD2, ($urandom % 4) == 0);
      sendByte(0, good ? {~lo, lo} : 8'($urandom), $urandom % 2);
    end
    idle(3);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired [%s]", phase);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule